// File: doc/BRIEF.md
# Filter Gate Handshake Controller

This block sits in front of a set of parallel transaction filter ports and decides, port by port, whether new requests may pass. Software drives it through one 32-bit control word: the low half holds one open/close request bit per port and the high half reports, read-only, whether each gate has actually reached the requested state. Status lags the request. An opening gate confirms one cycle after the request is seen. A closing gate stops admitting new requests at once, but reports closed only after every transaction it already let through has completed.

Each port is a valid/ready request pass-through with a parallel completion return path and an in-flight counter. The counter rises on each accepted request and falls on each accepted completion. Completions are never gated, so a closing port can drain. Software changes a gate by writing the request word and polling the status half until it matches.

Top module: `filter_gate_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every request bit, every status bit and every in-flight count. While all gates are shut, every port drives up_req_ready and dn_req_valid low.
- R2: Bit n of the control word (n below NUM_PORTS) is the request for port n, where 1 means open. Bit 16+n is the status of port n. reg_rdata shows, one clock after each edge, the status and request values that held before that edge.
- R3: A write stores only bits 0 to NUM_PORTS-1. Bits 16 and up, and request bits of ports that do not exist, are ignored and always read as 0.
- R4: When a port's stored request is 1 and its status is 0, the status becomes 1 at the next clock edge, unless that edge carries a cancelling write (R9).
- R5: A port admits requests only while its stored request and its status are both 1 and its count is below its maximum. While admitting, dn_req_valid equals up_req_valid, up_req_ready equals dn_req_ready, and dn_req_data equals up_req_data. Otherwise both handshake outputs are 0.
- R6: A write that clears a port's request bit stops admission from the edge that stores it. The status stays 1 until an edge at which the count is 0, and clears at that edge.
- R7: The completion path passes straight through in every gate state: up_cpl_valid equals dn_cpl_valid and dn_cpl_ready equals up_cpl_ready.
- R8: The count rises by one for each accepted request and falls by one for each accepted completion while it is nonzero. At its maximum, 2^CNT_W-1, no request is admitted, so the count never wraps.
- R9: A write whose bit for a port equals that port's current status cancels any pending change on that same edge. The status keeps its value and the request takes the written value.
- R10: Gates are independent: the request, status and count of one port never affect another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered snapshot of the control word |
| up_req_valid | input | NUM_PORTS | Request valid from each initiator |
| up_req_data | input | NUM_PORTS*DATA_W | Request payload, port n at slice n |
| up_req_ready | output | NUM_PORTS | Request ready to each initiator |
| dn_req_valid | output | NUM_PORTS | Request valid toward each filter |
| dn_req_data | output | NUM_PORTS*DATA_W | Request payload toward each filter |
| dn_req_ready | input | NUM_PORTS | Request ready from each filter |
| dn_cpl_valid | input | NUM_PORTS | Completion valid from each filter |
| dn_cpl_ready | output | NUM_PORTS | Completion ready toward each filter |
| up_cpl_valid | output | NUM_PORTS | Completion valid to each initiator |
| up_cpl_ready | input | NUM_PORTS | Completion ready from each initiator |

## Verification
The bound checker checks several rules on every cycle. A shut gate admits nothing. A status fall only follows a cycle with a zero count, and a status rise only follows a stored request of 1. A full counter blocks admission, and an empty counter with no admission stays empty. The completion path always passes through, and unused control-word bits always read 0. Only the bench's scenarios can show the exact latency of a status change after a write, the cancel of a change that has not yet taken effect, and the full fill-close-drain sequence. The bench checks these against a behavioural model on every clock and also with directed checks at known cycles.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = 16;

  // Phase of one gate, derived from {request, status}
  typedef enum logic [1:0] {
    GATE_SHUT     = 2'b00,
    GATE_DRAINING = 2'b01,
    GATE_OPENING  = 2'b10,
    GATE_LIVE     = 2'b11
  } gate_phase_e;

  function automatic gate_phase_e phase_of(input logic req, input logic st);
    return gate_phase_e'({req, st});
  endfunction
endpackage

// File: rtl/gk_regfile.sv
module gk_regfile
  import gk_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wdata,
  input  logic [NUM_PORTS-1:0] status,
  output logic [NUM_PORTS-1:0] request,
  output logic [REG_W-1:0]     rdata
);
  logic [NUM_PORTS-1:0] req_q;
  logic [REG_W-1:0]     snap;
  logic [REG_W-1:0]     rdata_q;

  // Only the low NUM_PORTS bits are stored; everything else is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
    end else if (wr_en) begin
      req_q <= wdata[NUM_PORTS-1:0];
    end
  end

  always_comb begin
    snap = '0;
    for (int n = 0; n < NUM_PORTS; n++) begin
      snap[n]          = req_q[n];
      snap[HALF_W + n] = status[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= snap;
    end
  end

  assign request = req_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/gk_inflight.sv
module gk_inflight #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             dec_ok;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_MAX);
  // A completion with nothing in flight is passed on but not counted
  assign dec_ok = dec && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/gk_port.sv
module gk_port
  import gk_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_bit,
  input  logic              wr_hit,
  input  logic              wr_bit,
  input  logic              up_req_valid,
  input  logic [DATA_W-1:0] up_req_data,
  output logic              up_req_ready,
  output logic              dn_req_valid,
  output logic [DATA_W-1:0] dn_req_data,
  input  logic              dn_req_ready,
  input  logic              dn_cpl_valid,
  output logic              dn_cpl_ready,
  output logic              up_cpl_valid,
  input  logic              up_cpl_ready,
  output logic              status,
  output logic [CNT_W-1:0]  count
);
  logic        st_q;
  logic        admit;
  logic        full;
  logic        empty;
  logic        revert;
  logic        st_n;
  gate_phase_e phase;

  assign phase  = phase_of(req_bit, st_q);
  assign admit  = (phase == GATE_LIVE) && !full;
  // A write that puts the request back to the current status cancels a pending change
  assign revert = wr_hit && (wr_bit == st_q);

  always_comb begin
    st_n = st_q;
    case (phase)
      GATE_OPENING:  if (!revert)          st_n = 1'b1;
      GATE_DRAINING: if (!revert && empty) st_n = 1'b0;
      default:       st_n = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= 1'b0;
    end else begin
      st_q <= st_n;
    end
  end

  assign dn_req_valid = up_req_valid && admit;
  assign up_req_ready = dn_req_ready && admit;
  assign dn_req_data  = up_req_data;
  assign up_cpl_valid = dn_cpl_valid;
  assign dn_cpl_ready = up_cpl_ready;

  gk_inflight #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (up_req_valid && up_req_ready),
    .dec   (dn_cpl_valid && up_cpl_ready),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  assign status = st_q;
endmodule

// File: rtl/filter_gate_ctrl.sv
module filter_gate_ctrl
  import gk_pkg::*;
#(
  parameter int NUM_PORTS = 4,  // 1..16
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr_en,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic [NUM_PORTS-1:0]        up_req_valid,
  input  logic [NUM_PORTS*DATA_W-1:0] up_req_data,
  output logic [NUM_PORTS-1:0]        up_req_ready,
  output logic [NUM_PORTS-1:0]        dn_req_valid,
  output logic [NUM_PORTS*DATA_W-1:0] dn_req_data,
  input  logic [NUM_PORTS-1:0]        dn_req_ready,
  input  logic [NUM_PORTS-1:0]        dn_cpl_valid,
  output logic [NUM_PORTS-1:0]        dn_cpl_ready,
  output logic [NUM_PORTS-1:0]        up_cpl_valid,
  input  logic [NUM_PORTS-1:0]        up_cpl_ready
);
  logic [NUM_PORTS-1:0]       req_vec;
  logic [NUM_PORTS-1:0]       st_vec;
  logic [NUM_PORTS*CNT_W-1:0] cnt_flat;

  gk_regfile #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wdata   (reg_wdata),
    .status  (st_vec),
    .request (req_vec),
    .rdata   (reg_rdata)
  );

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
    gk_port #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_port (
      .clk          (clk),
      .rst          (rst),
      .req_bit      (req_vec[n]),
      .wr_hit       (reg_wr_en),
      .wr_bit       (reg_wdata[n]),
      .up_req_valid (up_req_valid[n]),
      .up_req_data  (up_req_data[n*DATA_W +: DATA_W]),
      .up_req_ready (up_req_ready[n]),
      .dn_req_valid (dn_req_valid[n]),
      .dn_req_data  (dn_req_data[n*DATA_W +: DATA_W]),
      .dn_req_ready (dn_req_ready[n]),
      .dn_cpl_valid (dn_cpl_valid[n]),
      .dn_cpl_ready (dn_cpl_ready[n]),
      .up_cpl_valid (up_cpl_valid[n]),
      .up_cpl_ready (up_cpl_ready[n]),
      .status       (st_vec[n]),
      .count        (cnt_flat[n*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/gk_checker.sv
module gk_checker #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [31:0]                reg_rdata,
  input logic [NUM_PORTS-1:0]       up_req_valid,
  input logic [NUM_PORTS-1:0]       up_req_ready,
  input logic [NUM_PORTS-1:0]       dn_req_valid,
  input logic [NUM_PORTS-1:0]       dn_cpl_valid,
  input logic [NUM_PORTS-1:0]       dn_cpl_ready,
  input logic [NUM_PORTS-1:0]       up_cpl_valid,
  input logic [NUM_PORTS-1:0]       up_cpl_ready,
  input logic [NUM_PORTS-1:0]       req_vec,
  input logic [NUM_PORTS-1:0]       st_vec,
  input logic [NUM_PORTS*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [15:0] USED = 16'((32'd1 << NUM_PORTS) - 1);

  // R3: unused control-word bits always read zero
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata[15:0] & ~USED) == '0) && ((reg_rdata[31:16] & ~USED) == '0));

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_chk
    // R5 / R1: a gate whose status is 0 admits nothing
    p_shut_blocks_r5: assert property (@(posedge clk) disable iff (rst)
      !st_vec[n] |-> (!up_req_ready[n] && !dn_req_valid[n]));
    // R6: status only falls after a cycle with an empty count and the request cleared
    p_close_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(st_vec[n]) |-> ($past(cnt_flat[n*CNT_W +: CNT_W]) == '0 && !$past(req_vec[n])));
    // R4: status only rises after the stored request was 1
    p_open_follows_req_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(st_vec[n]) |-> $past(req_vec[n]));
    // R8: a full counter blocks admission
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[n*CNT_W +: CNT_W] == CNT_MAX) |-> !dn_req_valid[n] && !up_req_ready[n]);
    // R8: an empty counter with no admission stays empty
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[n*CNT_W +: CNT_W] == '0 && !(up_req_valid[n] && up_req_ready[n]))
      |=> (cnt_flat[n*CNT_W +: CNT_W] == '0));
    // R7: completions flow in every gate state
    p_cpl_flow_r7: assert property (@(posedge clk) disable iff (rst)
      (up_cpl_valid[n] == dn_cpl_valid[n]) && (dn_cpl_ready[n] == up_cpl_ready[n]));
  end
endmodule

bind filter_gate_ctrl gk_checker #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_gk_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_rdata    (reg_rdata),
  .up_req_valid (up_req_valid),
  .up_req_ready (up_req_ready),
  .dn_req_valid (dn_req_valid),
  .dn_cpl_valid (dn_cpl_valid),
  .dn_cpl_ready (dn_cpl_ready),
  .up_cpl_valid (up_cpl_valid),
  .up_cpl_ready (up_cpl_ready),
  .req_vec      (req_vec),
  .st_vec       (st_vec),
  .cnt_flat     (cnt_flat)
);

// File: tb/filter_gate_ctrl_tb.sv
module filter_gate_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NP    = 4;
  localparam int CW    = 3;
  localparam int DW    = 8;
  localparam int MAXC  = (1 << CW) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr_en = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [NP-1:0]    up_req_valid = '0;
  logic [NP*DW-1:0] up_req_data = '0;
  logic [NP-1:0]    up_req_ready;
  logic [NP-1:0]    dn_req_valid;
  logic [NP*DW-1:0] dn_req_data;
  logic [NP-1:0]    dn_req_ready = '0;
  logic [NP-1:0]    dn_cpl_valid = '0;
  logic [NP-1:0]    dn_cpl_ready;
  logic [NP-1:0]    up_cpl_valid;
  logic [NP-1:0]    up_cpl_ready = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  filter_gate_ctrl #(.NUM_PORTS(NP), .CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .up_req_valid(up_req_valid), .up_req_data(up_req_data),
    .up_req_ready(up_req_ready), .dn_req_valid(dn_req_valid), .dn_req_data(dn_req_data),
    .dn_req_ready(dn_req_ready), .dn_cpl_valid(dn_cpl_valid), .dn_cpl_ready(dn_cpl_ready),
    .up_cpl_valid(up_cpl_valid), .up_cpl_ready(up_cpl_ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int          m_req [NP];
  int          m_st  [NP];
  int          m_cnt [NP];
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin : model
    logic [31:0] rd;
    if (rst) begin
      for (int n = 0; n < NP; n++) begin
        m_req[n] = 0; m_st[n] = 0; m_cnt[n] = 0;
      end
      m_rdata = '0;
    end else begin
      rd = '0;
      for (int n = 0; n < NP; n++) begin
        rd[n]      = (m_req[n] != 0);
        rd[16 + n] = (m_st[n] != 0);
      end
      m_rdata = rd;
      for (int n = 0; n < NP; n++) begin
        int  wb;
        bit  adm, acc, cpl, cancel;
        wb     = int'(reg_wdata[n]);
        adm    = (m_req[n] == 1) && (m_st[n] == 1) && (m_cnt[n] < MAXC);
        acc    = adm && up_req_valid[n] && dn_req_ready[n];
        cpl    = dn_cpl_valid[n] && up_cpl_ready[n] && (m_cnt[n] > 0);
        cancel = reg_wr_en && (wb == m_st[n]);
        if (m_req[n] != m_st[n] && !cancel && (m_req[n] == 1 || m_cnt[n] == 0))
          m_st[n] = m_req[n];
        m_cnt[n] = m_cnt[n] + (acc ? 1 : 0) - (cpl ? 1 : 0);
        if (reg_wr_en) m_req[n] = wb;
      end
    end
  end

  // Comparison every cycle, after the bench has driven new inputs
  always @(negedge clk) begin
    #1;
    check("R2 rdata", reg_rdata, m_rdata);
    for (int n = 0; n < NP; n++) begin
      bit adm;
      adm = (m_req[n] == 1) && (m_st[n] == 1) && (m_cnt[n] < MAXC);
      check("R5 up_req_ready", 32'(up_req_ready[n]), 32'(dn_req_ready[n] && adm));
      check("R5 dn_req_valid", 32'(dn_req_valid[n]), 32'(up_req_valid[n] && adm));
      if (dn_req_valid[n])
        check("R5 dn_req_data", 32'(dn_req_data[n*DW +: DW]), 32'(up_req_data[n*DW +: DW]));
      check("R7 up_cpl_valid", 32'(up_cpl_valid[n]), 32'(dn_cpl_valid[n]));
      check("R7 dn_cpl_ready", 32'(dn_cpl_ready[n]), 32'(up_cpl_ready[n]));
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    cyc(3);
    #2;
    check("R1 rdata after reset", reg_rdata, 32'h0);
    check("R1 ready after reset", 32'(up_req_ready), 32'h0);
    @(negedge clk); rst = 1'b0;
    up_req_valid = 4'b0001; dn_req_ready = 4'b0001; up_cpl_ready = '1;
    up_req_data  = 32'hA5A5_A5A5;

    // Open port 0; upper half and absent-port bits must be ignored
    wr(32'hFFFF_FFF1);
    #2; check("R4 not yet open", 32'(up_req_ready[0]), 32'h0);
    cyc(1); #2;
    check("R2 request visible", reg_rdata, 32'h0000_0001);
    check("R4 open one edge later", 32'(up_req_ready[0]), 32'h1);
    cyc(1); #2;
    check("R3 ignored bits", reg_rdata, 32'h0001_0001);

    // Fill port 0 to its maximum count
    cyc(MAXC + 2); #2;
    check("R8 full blocks", 32'(up_req_ready[0]), 32'h0);

    // Close with requests in flight: status holds
    wr(32'h0);
    cyc(3); #2;
    check("R6 status held while busy", reg_rdata, 32'h0001_0000);
    dn_cpl_valid = 4'b0001;
    #2; check("R7 cpl flows while closing", 32'(up_cpl_valid[0]), 32'h1);
    cyc(MAXC);
    dn_cpl_valid = '0;
    cyc(3); #2;
    check("R6 closed after drain", reg_rdata, 32'h0);

    // Cancel: open request on port 1 withdrawn on the next write
    up_req_valid = 4'b0010; dn_req_ready = 4'b0010;
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = 32'h2;
    @(negedge clk); reg_wdata = 32'h0;
    @(negedge clk); reg_wr_en = 1'b0;
    cyc(3); #2;
    check("R9 cancel leaves shut", reg_rdata, 32'h0);
    check("R9 never admitted", 32'(up_req_ready[1]), 32'h0);

    // Independence: open 0 and 1, then close only 0
    up_req_valid = 4'b0011; dn_req_ready = 4'b0011;
    wr(32'h3);
    cyc(4);
    up_req_valid = '0; dn_cpl_valid = '1;
    cyc(10);
    dn_cpl_valid = '0;
    wr(32'h2);
    cyc(3); #2;
    check("R10 port1 unaffected", reg_rdata, 32'h0002_0002);

    // Random traffic and writes
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      up_req_valid = NP'($urandom);
      dn_req_ready = NP'($urandom);
      dn_cpl_valid = NP'($urandom);
      up_cpl_ready = NP'($urandom);
      up_req_data  = ($urandom);
      reg_wr_en    = (($urandom % 12) == 0);
      reg_wdata    = $urandom;
    end
    @(negedge clk); reg_wr_en = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule